// File: doc/BRIEF.md
# Dual-Port Address Collision Arbiter

This block sits beside a two-port memory of 1K locations and watches both access ports. When both ports are selected in the same cycle and point at the same location, it picks the port that reached that location first as the winner. It raises an active-low busy flag toward the other port and withholds that port's write permission. The memory only commits a write from a port in the cycles where the arbiter's write-allowed output for that port is high.

The model is fully synchronous on one clock, and every output comes from a register. A collision sampled at a rising edge shows up on the outputs right after that edge. The outputs reflect the inputs sampled at the most recent edge. "Arrived first" means the port's select and address were already present, unchanged, at the previous sampling edge. If neither port was settled, the left port wins the tie. Once a port holds the grant, it keeps it until the two ports stop colliding.

Top module: `dp_collision_arbiter`

## Requirements
- R1: When both selects are active (`ce_*_n` low) and both addresses are equal at a sampling edge, exactly one of `busy_l_n` / `busy_r_n` is low after that edge.
- R2: When either select is inactive or the addresses differ at a sampling edge, both busy outputs are high after that edge.
- R3: If one port was selected on the colliding address at the previous edge and the other port was not, the newly arriving port is the one marked busy.
- R4: `busy_l_n` and `busy_r_n` are never low together.
- R5: `wr_ok_*` is high after an edge exactly when that port was selected with `we_*_n` low at that edge and is not marked busy. A busy port's write is withheld.
- R6: Busy is released after the first edge at which the addresses differ or either select is inactive.
- R7: When both ports start colliding in the same cycle with neither settled, the left port wins and `busy_r_n` goes low.
- R8: The grant holder keeps the grant for as long as the collision continues, even while either port toggles its read/write line.
- R9: The winning port's `wr_ok` keeps following its own write request during a collision. Reads on either port are never gated.
- R10: While `rst_n` is low at an edge, both busy outputs go high and both `wr_ok` outputs go low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| ce_l_n | input | 1 | Left port select, active low |
| we_l_n | input | 1 | Left port read/write, low = write |
| addr_l | input | ADDR_W | Left port address |
| ce_r_n | input | 1 | Right port select, active low |
| we_r_n | input | 1 | Right port read/write, low = write |
| addr_r | input | ADDR_W | Right port address |
| busy_l_n | output | 1 | Left port busy, active low |
| busy_r_n | output | 1 | Right port busy, active low |
| wr_ok_l | output | 1 | Left write permitted, active high |
| wr_ok_r | output | 1 | Right write permitted, active high |

## Verification
The bench aims at arrival order: a port already settled on the address must win from either side. A design that judged arrival by port position alone would wrongly mark the settled right port busy. Same-cycle arrival, whether from idle or from two ports leaving different addresses together, must hand the grant to the left port and never raise both flags; a naive "changed this cycle" rule would flag both or neither. Write and read toggling during a held collision checks that the grant does not flip over to the toggling port and that the winner's write permission keeps tracking its own request. Release is probed both by an address change and by a deselect, to catch a grant that sticks past the collision.

// File: rtl/dpca_pkg.sv
// Shared types for the dual-port collision arbiter.
// Assumes: exactly two ports, index 0 = left, index 1 = right.
package dpca_pkg;

    localparam int NUM_PORTS = 2;
    localparam int PORT_L    = 0;
    localparam int PORT_R    = 1;

    // Which port currently holds the grant on a colliding address.
    typedef enum logic [1:0] {
        OWN_NONE  = 2'd0,
        OWN_LEFT  = 2'd1,
        OWN_RIGHT = 2'd2
    } owner_e;

endpackage

// File: rtl/dpca_port_tracker.sv
// Per-port arrival tracker.
// Remembers the select and address seen at the previous edge and reports
// whether the port is "settled": selected now, and selected on the same
// address at the previous edge.
// Assumes: en is the active-high form of the port select.
module dpca_port_tracker #(
    parameter int ADDR_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic [ADDR_W-1:0] addr,
    output logic              settled
);

    logic              prev_en_q;
    logic [ADDR_W-1:0] prev_addr_q;

    // Capture this cycle's select and address for next cycle's comparison.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_en_q   <= 1'b0;
            prev_addr_q <= '0;
        end else begin
            prev_en_q   <= en;
            prev_addr_q <= addr;
        end
    end

    // Settled when unchanged and selected across two consecutive samples.
    always_comb begin
        settled = en && prev_en_q && (prev_addr_q == addr);
    end

endmodule

// File: rtl/dpca_grant_fsm.sv
// Grant holder for a collision.
// Keeps the current owner while the collision continues. On a fresh
// collision it grants the settled port, and the left port when the order
// is undecided.
// Assumes: collide is the same-cycle collision condition of both ports.
module dpca_grant_fsm
    import dpca_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   collide,
    input  logic   settled_l,
    input  logic   settled_r,
    output owner_e owner_d
);

    owner_e owner_q;

    // Next owner: clear off collision, hold while owned, else decide by arrival.
    always_comb begin
        if (!collide) begin
            owner_d = OWN_NONE;
        end else if (owner_q != OWN_NONE) begin
            owner_d = owner_q;
        end else if (settled_r && !settled_l) begin
            owner_d = OWN_RIGHT;
        end else begin
            owner_d = OWN_LEFT;
        end
    end

    // Owner register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            owner_q <= OWN_NONE;
        end else begin
            owner_q <= owner_d;
        end
    end

endmodule

// File: rtl/dpca_out_stage.sv
// Output register stage.
// Turns the next owner and the write requests into registered busy flags
// (active low) and write permissions (active high).
// Assumes: owner_d is OWN_NONE whenever there is no collision.
module dpca_out_stage
    import dpca_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  owner_e owner_d,
    input  logic   wreq_l,
    input  logic   wreq_r,
    output logic   busy_l_n,
    output logic   busy_r_n,
    output logic   wr_ok_l,
    output logic   wr_ok_r
);

    logic lose_l;
    logic lose_r;

    // A port loses when the other port owns the collision.
    always_comb begin
        lose_l = (owner_d == OWN_RIGHT);
        lose_r = (owner_d == OWN_LEFT);
    end

    // Register busy flags and gated write permissions.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_l_n <= 1'b1;
            busy_r_n <= 1'b1;
            wr_ok_l  <= 1'b0;
            wr_ok_r  <= 1'b0;
        end else begin
            busy_l_n <= !lose_l;
            busy_r_n <= !lose_r;
            wr_ok_l  <= wreq_l && !lose_l;
            wr_ok_r  <= wreq_r && !lose_r;
        end
    end

endmodule

// File: rtl/dp_collision_arbiter.sv
// Dual-port address collision arbiter (top).
// Detects both ports selected on the same address, grants the earlier
// port and flags the later one busy, withholding its write permission.
// Assumes: active-low selects and write lines, one clock, sync reset.
module dp_collision_arbiter
    import dpca_pkg::*;
#(
    parameter int ADDR_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce_l_n,
    input  logic              we_l_n,
    input  logic [ADDR_W-1:0] addr_l,
    input  logic              ce_r_n,
    input  logic              we_r_n,
    input  logic [ADDR_W-1:0] addr_r,
    output logic              busy_l_n,
    output logic              busy_r_n,
    output logic              wr_ok_l,
    output logic              wr_ok_r
);

    logic [NUM_PORTS-1:0] en;
    logic [NUM_PORTS-1:0] settled;
    logic [ADDR_W-1:0]    addr_v [NUM_PORTS];
    logic                 collide;
    logic                 wreq_l;
    logic                 wreq_r;
    owner_e               owner_d;

    // Active-high views of each port's select and write request.
    always_comb begin
        en[PORT_L]     = !ce_l_n;
        en[PORT_R]     = !ce_r_n;
        addr_v[PORT_L] = addr_l;
        addr_v[PORT_R] = addr_r;
        wreq_l         = !ce_l_n && !we_l_n;
        wreq_r         = !ce_r_n && !we_r_n;
    end

    // Collision: both selected on the same address.
    always_comb begin
        collide = en[PORT_L] && en[PORT_R] && (addr_l == addr_r);
    end

    // One arrival tracker per port.
    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
        dpca_port_tracker #(
            .ADDR_W (ADDR_W)
        ) i_trk (
            .clk     (clk),
            .rst_n   (rst_n),
            .en      (en[p]),
            .addr    (addr_v[p]),
            .settled (settled[p])
        );
    end

    dpca_grant_fsm i_grant (
        .clk       (clk),
        .rst_n     (rst_n),
        .collide   (collide),
        .settled_l (settled[PORT_L]),
        .settled_r (settled[PORT_R]),
        .owner_d   (owner_d)
    );

    dpca_out_stage i_out (
        .clk      (clk),
        .rst_n    (rst_n),
        .owner_d  (owner_d),
        .wreq_l   (wreq_l),
        .wreq_r   (wreq_r),
        .busy_l_n (busy_l_n),
        .busy_r_n (busy_r_n),
        .wr_ok_l  (wr_ok_l),
        .wr_ok_r  (wr_ok_r)
    );

endmodule

// File: rtl/dpca_checker.sv
// Property checker for dp_collision_arbiter, attached with bind.
// Observes only the top-level ports.
module dpca_checker #(
    parameter int ADDR_W = 10
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ce_l_n,
    input logic              we_l_n,
    input logic [ADDR_W-1:0] addr_l,
    input logic              ce_r_n,
    input logic              we_r_n,
    input logic [ADDR_W-1:0] addr_r,
    input logic              busy_l_n,
    input logic              busy_r_n,
    input logic              wr_ok_l,
    input logic              wr_ok_r
);

    logic hit;

    // Collision condition as seen on the ports.
    always_comb begin
        hit = !ce_l_n && !ce_r_n && (addr_l == addr_r);
    end

    AST_ONE_BUSY_ON_HIT: assert property (@(posedge clk) disable iff (!rst_n)
        hit |=> (busy_l_n != busy_r_n)); // R1

    AST_IDLE_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        !hit |=> (busy_l_n && busy_r_n)); // R2

    AST_BUSY_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_l_n || busy_r_n)); // R4

    AST_BUSY_L_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_l_n |-> !wr_ok_l); // R5

    AST_BUSY_R_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_r_n |-> !wr_ok_r); // R5

    AST_WRITE_NEEDS_REQ_L: assert property (@(posedge clk) disable iff (!rst_n)
        (ce_l_n || !we_l_n == 1'b0) |=> !wr_ok_l); // R5

    AST_HOLD_L_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && !busy_l_n) |=> !busy_l_n); // R8

    AST_HOLD_R_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && !busy_r_n) |=> !busy_r_n); // R8

endmodule

bind dp_collision_arbiter dpca_checker #(.ADDR_W(ADDR_W)) i_dpca_checker (
    .clk      (clk),
    .rst_n    (rst_n),
    .ce_l_n   (ce_l_n),
    .we_l_n   (we_l_n),
    .addr_l   (addr_l),
    .ce_r_n   (ce_r_n),
    .we_r_n   (we_r_n),
    .addr_r   (addr_r),
    .busy_l_n (busy_l_n),
    .busy_r_n (busy_r_n),
    .wr_ok_l  (wr_ok_l),
    .wr_ok_r  (wr_ok_r)
);

// File: tb/test_dp_collision_arbiter.sv
// Directed bench: one task per scenario, each checking its own results.
module test_dp_collision_arbiter;

    localparam int ADDR_W = 10;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              ce_l_n = 1'b1;
    logic              we_l_n = 1'b1;
    logic [ADDR_W-1:0] addr_l = '0;
    logic              ce_r_n = 1'b1;
    logic              we_r_n = 1'b1;
    logic [ADDR_W-1:0] addr_r = '0;
    logic              busy_l_n;
    logic              busy_r_n;
    logic              wr_ok_l;
    logic              wr_ok_r;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #10 clk = ~clk;

    dp_collision_arbiter #(.ADDR_W(ADDR_W)) i_dp_collision_arbiter (
        .clk      (clk),
        .rst_n    (rst_n),
        .ce_l_n   (ce_l_n),
        .we_l_n   (we_l_n),
        .addr_l   (addr_l),
        .ce_r_n   (ce_r_n),
        .we_r_n   (we_r_n),
        .addr_r   (addr_r),
        .busy_l_n (busy_l_n),
        .busy_r_n (busy_r_n),
        .wr_ok_l  (wr_ok_l),
        .wr_ok_r  (wr_ok_r)
    );

    // Set both ports' inputs (called just after a falling edge).
    task automatic drive(input logic cl, input logic wl, input int al,
                         input logic cr, input logic wr, input int ar);
        ce_l_n = cl; we_l_n = wl; addr_l = ADDR_W'(al);
        ce_r_n = cr; we_r_n = wr; addr_r = ADDR_W'(ar);
    endtask

    // Let the inputs be sampled at one rising edge, return at the next falling edge.
    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    // Compare all four outputs against expectations.
    task automatic expect_out(input string req, input logic bl, input logic br,
                              input logic wl, input logic wr);
        n_checks++;
        if (busy_l_n !== bl || busy_r_n !== br || wr_ok_l !== wl || wr_ok_r !== wr) begin
            n_fail++;
            $display("FAIL %s: busy_l_n/busy_r_n/wr_ok_l/wr_ok_r actual %b%b%b%b expected %b%b%b%b",
                     req, busy_l_n, busy_r_n, wr_ok_l, wr_ok_r, bl, br, wl, wr);
        end
    endtask

    task automatic idle();
        drive(1, 1, 0, 1, 1, 0);
        step();
    endtask

    task automatic t_reset();
        drive(0, 0, 7, 0, 0, 7);
        rst_n = 1'b0;
        step();
        step();
        expect_out("R10 reset state", 1, 1, 0, 0);
        drive(1, 1, 0, 1, 1, 0);
        rst_n = 1'b1;
        step();
    endtask

    task automatic t_no_collision();
        drive(0, 0, 12, 0, 0, 13);
        step();
        expect_out("R2 different addresses", 1, 1, 1, 1);
        drive(0, 0, 20, 1, 0, 20);
        step();
        expect_out("R2 right deselected", 1, 1, 1, 0);
        drive(1, 0, 20, 0, 0, 20);
        step();
        expect_out("R2 left deselected", 1, 1, 0, 1);
        idle();
    endtask

    task automatic t_left_first();
        drive(0, 1, 5, 1, 1, 5);
        step();
        expect_out("R2 left alone", 1, 1, 0, 0);
        drive(0, 0, 5, 0, 0, 5);
        step();
        expect_out("R3 R1 R5 R9 right arrives late", 1, 0, 1, 0);
        drive(0, 1, 5, 0, 1, 5);
        step();
        expect_out("R8 hold while both read", 1, 0, 0, 0);
        drive(0, 0, 5, 0, 0, 5);
        step();
        expect_out("R8 R9 hold, winner writes", 1, 0, 1, 0);
        drive(0, 0, 5, 0, 0, 6);
        step();
        expect_out("R6 release on address change", 1, 1, 1, 1);
        idle();
    endtask

    task automatic t_right_first();
        drive(1, 1, 9, 0, 0, 9);
        step();
        expect_out("R5 right alone writes", 1, 1, 0, 1);
        drive(0, 0, 9, 0, 0, 9);
        step();
        expect_out("R3 R5 left arrives late", 0, 1, 0, 1);
        drive(0, 1, 9, 0, 1, 9);
        step();
        expect_out("R8 hold with read toggle", 0, 1, 0, 0);
        drive(0, 0, 9, 0, 0, 9);
        step();
        expect_out("R8 R9 hold, right writes", 0, 1, 0, 1);
        drive(0, 0, 9, 1, 0, 9);
        step();
        expect_out("R6 release on deselect", 1, 1, 1, 0);
        idle();
    endtask

    task automatic t_tie_from_idle();
        drive(0, 0, 1023, 0, 0, 1023);
        step();
        expect_out("R7 R4 same-cycle arrival", 1, 0, 1, 0);
        step();
        expect_out("R8 tie grant held", 1, 0, 1, 0);
        idle();
        expect_out("R6 release after tie", 1, 1, 0, 0);
    endtask

    task automatic t_tie_from_moving();
        drive(0, 1, 100, 0, 1, 200);
        step();
        expect_out("R2 both reading apart", 1, 1, 0, 0);
        drive(0, 1, 300, 0, 0, 300);
        step();
        expect_out("R7 both move onto one address", 1, 0, 0, 0);
        drive(0, 1, 300, 0, 0, 301);
        step();
        expect_out("R6 right moves away", 1, 1, 0, 1);
        drive(0, 1, 301, 0, 0, 301);
        step();
        expect_out("R3 left joins settled right", 0, 1, 0, 1);
        idle();
    endtask

    // Watchdog: a hung run counts as one failed check.
    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        t_reset();
        t_no_collision();
        t_left_first();
        t_right_first();
        t_tie_from_idle();
        t_tie_from_moving();
        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule